// File: doc/BRIEF.md
# Layered Packet Header Parser

This block is a streaming parser for frames that arrive one byte per cycle, with start-of-frame and end-of-frame markers. It walks a fixed branching parse graph. The link-layer header comes first. Its type field selects either an IPv4 or an IPv6 header. The protocol or next-header value of that IP header then selects a TCP or a UDP header. Each header has a fixed length. Length fields inside the headers are never used to skip options or extensions. The captured headers, one valid flag per layer, and a five-tuple for a downstream lookup are presented together under a single-cycle result strobe.

The frame itself is forwarded unchanged on a byte output, one cycle behind the input. Parsing stops in one of four ways, and the strobe fires in the cycle after the byte on which parsing stopped:
- the final header of the branch completes;
- a type or protocol value leads nowhere;
- the frame ends early;
- the number of bytes spent in header states reaches the configured depth limit.

The bytes that follow the stop point are forwarded but not parsed.

The controller has seven states:
- `ST_IDLE` waits for a start byte.
- `ST_ETH`, `ST_IP4`, `ST_IP6`, `ST_TCP` and `ST_UDP` each shift in one header.
- `ST_SKIP` lets the rest of the frame pass until its end.

It takes these transitions:
- *start*: a start byte from any state enters `ST_ETH`.
- *chain*: a completed header moves to the header it selects.
- *accept*: a completed header that selects nothing goes to `ST_SKIP`, or to `ST_IDLE` if that byte also ends the frame.
- *cut*: an end byte inside a header goes to `ST_IDLE`.
- *cap*: reaching the depth limit goes to `ST_SKIP`, or to `ST_IDLE` on an end byte.
- *drain*: an end byte in `ST_SKIP` goes to `ST_IDLE`.

Top module: `pkt_hdr_parser`

## Requirements
- R1: After reset, `res_valid`, `out_valid`, `res_trunc`, `res_depth` and all five layer flags are low.
- R2: `out_valid`, `out_data`, `out_sof` and `out_eof` repeat `in_valid`, `in_data`, `in_sof` and `in_eof` exactly one cycle later, for every byte of every frame, with no byte dropped or altered.
- R3: The first 14 bytes of a frame form `eth_hdr`. The first byte lands in the most significant byte. This gives destination address in [111:64], source address in [63:16] and type in [15:0].
- R4: Type 0x0800 selects IPv4 and type 0x86DD selects IPv6. Any other type stops parsing after byte 13, with only `eth_ok` set. At most one of `ip4_ok` and `ip6_ok` is ever set.
- R5: An IPv4 header is taken as exactly 20 bytes into `ip4_hdr`, first byte most significant. Protocol is in [87:80], source in [63:32] and destination in [31:0]. The header-length nibble does not change the byte count.
- R6: An IPv6 header is taken as exactly 40 bytes into `ip6_hdr`, first byte most significant. Next header is in [271:264], source in [255:128] and destination in [127:0].
- R7: In either IP state, a value of 6 selects TCP and 17 selects UDP. Any other value stops parsing after the IP header, with the IP flag set and both transport flags low.
- R8: A TCP header is taken as exactly 20 bytes into `tcp_hdr`, with ports in [159:144] and [143:128]. A UDP header is taken as exactly 8 bytes into `udp_hdr`, with ports in [63:48] and [47:32]. The TCP data-offset nibble does not change the byte count.
- R9: `res_valid` is high for exactly one cycle per started frame. That cycle is the one after the byte on which parsing stopped. Idle cycles inside a frame (`in_valid` low) do not advance the parse.
- R10: The five-tuple fields are filled as follows, each reading zero when its layer is absent:
  - `tup_proto` is the IPv4 protocol or the IPv6 next header.
  - `tup_src` and `tup_dst` are the IP addresses, with IPv4 addresses zero-extended to 128 bits.
  - `tup_sport` and `tup_dport` are the TCP or UDP ports.
- R11: A frame can end before a header is complete. This includes a header that was only just selected on that last byte. In that case the header's flag stays low, `res_trunc` is high with the result, and the strobe follows the end byte.
- R12: Let D be `PARSE_DEPTH_BITS`/8 bytes. When byte D of a frame is consumed in a header state and more header bytes are still needed, parsing stops. The incomplete header's flag stays low and `res_depth` is high. The depth condition takes precedence over truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | Forwarded first-of-frame marker |
| out_eof | output | 1 | Forwarded last-of-frame marker |
| res_valid | output | 1 | One-cycle parse result strobe |
| res_trunc | output | 1 | Frame ended inside a selected header |
| res_depth | output | 1 | Depth limit stopped parsing |
| eth_ok | output | 1 | Link-layer header captured |
| ip4_ok | output | 1 | IPv4 header captured |
| ip6_ok | output | 1 | IPv6 header captured |
| tcp_ok | output | 1 | TCP header captured |
| udp_ok | output | 1 | UDP header captured |
| eth_hdr | output | 112 | Link-layer header bytes |
| ip4_hdr | output | 160 | IPv4 header bytes |
| ip6_hdr | output | 320 | IPv6 header bytes |
| tcp_hdr | output | 160 | TCP header bytes |
| udp_hdr | output | 64 | UDP header bytes |
| tup_proto | output | 8 | Transport protocol number |
| tup_src | output | 128 | Source IP address |
| tup_dst | output | 128 | Destination IP address |
| tup_sport | output | 16 | Source port |
| tup_dport | output | 16 | Destination port |

## Verification
The hardest case to reach from the ports is the depth cap. With the default limit, no legal header chain comes near it. The bench therefore builds the block with a 70-byte limit, so that an IPv6 plus TCP frame runs into the cap in the middle of the TCP header.

The other hard cases sit on the boundary between a header that completes and one that was selected but never arrives:
- a frame that ends exactly on the type bytes of an IPv4 frame;
- frames that end inside the IPv4, link-layer and UDP headers;
- a frame whose final transport byte is also the end byte.

A one-cycle gap inside a header confirms that only accepted bytes advance the parse.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

    // Fixed header sizes in bytes
    localparam int ETH_BYTES = 14;
    localparam int IP4_BYTES = 20;
    localparam int IP6_BYTES = 40;
    localparam int TCP_BYTES = 20;
    localparam int UDP_BYTES = 8;

    localparam int ETH_W = ETH_BYTES * 8;
    localparam int IP4_W = IP4_BYTES * 8;
    localparam int IP6_W = IP6_BYTES * 8;
    localparam int TCP_W = TCP_BYTES * 8;
    localparam int UDP_W = UDP_BYTES * 8;

    // Layer index for flag vectors
    localparam int H_ETH = 0;
    localparam int H_IP4 = 1;
    localparam int H_IP6 = 2;
    localparam int H_TCP = 3;
    localparam int H_UDP = 4;
    localparam int NHDR  = 5;

    localparam logic [15:0] TYPE_IPV4 = 16'h0800;
    localparam logic [15:0] TYPE_IPV6 = 16'h86DD;
    localparam logic [7:0]  PROTO_TCP = 8'd6;
    localparam logic [7:0]  PROTO_UDP = 8'd17;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ETH,
        ST_IP4,
        ST_IP6,
        ST_TCP,
        ST_UDP,
        ST_SKIP
    } pst_t;

    function automatic logic [5:0] hdr_len(pst_t s);
        case (s)
            ST_ETH:  return 6'(ETH_BYTES);
            ST_IP4:  return 6'(IP4_BYTES);
            ST_IP6:  return 6'(IP6_BYTES);
            ST_TCP:  return 6'(TCP_BYTES);
            ST_UDP:  return 6'(UDP_BYTES);
            default: return 6'd1;
        endcase
    endfunction

endpackage

// File: rtl/hdr_shift.sv
// Byte shift register that captures one header, first byte ending up most significant.
module hdr_shift #(
    parameter int NBYTES = 14,
    localparam int W = NBYTES * 8
) (
    input  logic         clk,
    input  logic         en,
    input  logic [7:0]   din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (en) begin
            q <= {q[W-9:0], din};
        end
    end

endmodule

// File: rtl/hdr_stream_delay.sv
// One register stage for the forwarded frame bytes.
module hdr_stream_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          i_valid,
    input  logic [DW-1:0] i_data,
    input  logic          i_sof,
    input  logic          i_eof,
    output logic          o_valid,
    output logic [DW-1:0] o_data,
    output logic          o_sof,
    output logic          o_eof
);

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_sof   <= 1'b0;
            o_eof   <= 1'b0;
            o_data  <= '0;
        end else begin
            o_valid <= i_valid;
            o_sof   <= i_sof;
            o_eof   <= i_eof;
            o_data  <= i_data;
        end
    end

endmodule

// File: rtl/hdr_parse_fsm.sv
// Parse-graph controller: walks the header chain one byte per beat.
module hdr_parse_fsm
    import hdr_pkg::*;
#(
    parameter int DEPTH_BYTES = 1518,
    localparam int POS_W = $clog2(DEPTH_BYTES + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            beat,
    input  logic            sof,
    input  logic            eof,
    input  logic [15:0]     eth_type,
    input  logic [7:0]      ip4_proto,
    input  logic [7:0]      ip6_nh,
    output logic [NHDR-1:0] shift_en,
    output logic [NHDR-1:0] hdr_done,
    output logic            frame_start,
    output logic            publish,
    output logic            trunc_evt,
    output logic            depth_evt
);

    pst_t             st, st_n, cur_st, nxt_hdr;
    logic [5:0]       cnt, cnt_n, cur_cnt;
    logic [POS_W-1:0] pos, pos_n, cur_pos;
    logic             active, last, chained, at_cap;

    // Decode and next-state process
    always_comb begin
        frame_start = beat & sof;
        cur_st  = frame_start ? ST_ETH : st;
        cur_cnt = frame_start ? 6'd0 : cnt;
        cur_pos = frame_start ? '0 : pos;

        active = beat & (cur_st inside {ST_ETH, ST_IP4, ST_IP6, ST_TCP, ST_UDP});
        last   = active & (cur_cnt == hdr_len(cur_st) - 6'd1);

        nxt_hdr = ST_SKIP;
        unique case (cur_st)
            ST_ETH: begin
                if (eth_type == TYPE_IPV4)      nxt_hdr = ST_IP4;
                else if (eth_type == TYPE_IPV6) nxt_hdr = ST_IP6;
            end
            ST_IP4: begin
                if (ip4_proto == PROTO_TCP)      nxt_hdr = ST_TCP;
                else if (ip4_proto == PROTO_UDP) nxt_hdr = ST_UDP;
            end
            ST_IP6: begin
                if (ip6_nh == PROTO_TCP)      nxt_hdr = ST_TCP;
                else if (ip6_nh == PROTO_UDP) nxt_hdr = ST_UDP;
            end
            default: nxt_hdr = ST_SKIP;
        endcase

        chained   = last & (nxt_hdr != ST_SKIP);
        at_cap    = active & (cur_pos == POS_W'(DEPTH_BYTES - 1));
        depth_evt = at_cap & (~last | chained);
        trunc_evt = active & eof & ~depth_evt & (~last | chained);
        publish   = active & ((last & ~chained) | depth_evt | eof);

        st_n  = st;
        cnt_n = cnt;
        pos_n = pos;
        if (publish) begin
            st_n  = eof ? ST_IDLE : ST_SKIP;
            cnt_n = 6'd0;
        end else if (last) begin
            st_n  = nxt_hdr;
            cnt_n = 6'd0;
            pos_n = cur_pos + POS_W'(1);
        end else if (active) begin
            st_n  = cur_st;
            cnt_n = cur_cnt + 6'd1;
            pos_n = cur_pos + POS_W'(1);
        end else if (beat & eof & (st == ST_SKIP)) begin
            st_n = ST_IDLE;
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= 6'd0;
            pos <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            pos <= pos_n;
        end
    end

    // Output process: per-layer shift enables and completion strobes
    always_comb begin
        shift_en = '0;
        if (active) begin
            unique case (cur_st)
                ST_ETH:  shift_en[H_ETH] = 1'b1;
                ST_IP4:  shift_en[H_IP4] = 1'b1;
                ST_IP6:  shift_en[H_IP6] = 1'b1;
                ST_TCP:  shift_en[H_TCP] = 1'b1;
                ST_UDP:  shift_en[H_UDP] = 1'b1;
                default: shift_en = '0;
            endcase
        end
        hdr_done = last ? shift_en : '0;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st inside {ST_ETH, ST_IP4, ST_IP6, ST_TCP, ST_UDP}) |-> (cnt < hdr_len(st)))
        else $error("byte count ran past header length"); // R8

    AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st inside {ST_ETH, ST_IP4, ST_IP6, ST_TCP, ST_UDP}) |-> (pos < POS_W'(DEPTH_BYTES)))
        else $error("header walk passed depth limit"); // R12

endmodule

// File: rtl/pkt_hdr_parser.sv
module pkt_hdr_parser
    import hdr_pkg::*;
#(
    parameter int PARSE_DEPTH_BITS = 12144,
    localparam int DEPTH_BYTES = PARSE_DEPTH_BITS / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic             res_valid,
    output logic             res_trunc,
    output logic             res_depth,
    output logic             eth_ok,
    output logic             ip4_ok,
    output logic             ip6_ok,
    output logic             tcp_ok,
    output logic             udp_ok,
    output logic [ETH_W-1:0] eth_hdr,
    output logic [IP4_W-1:0] ip4_hdr,
    output logic [IP6_W-1:0] ip6_hdr,
    output logic [TCP_W-1:0] tcp_hdr,
    output logic [UDP_W-1:0] udp_hdr,
    output logic [7:0]       tup_proto,
    output logic [127:0]     tup_src,
    output logic [127:0]     tup_dst,
    output logic [15:0]      tup_sport,
    output logic [15:0]      tup_dport
);

    logic [NHDR-1:0] shift_en, hdr_done, hdr_ok;
    logic            frame_start, publish, trunc_evt, depth_evt;
    logic [15:0]     sel_type;
    logic [7:0]      sel_proto4, sel_nh6;
    logic            pt_armed;

    // Selector bytes as seen on the final byte of each header:
    // type is the last two bytes (one already stored, one arriving),
    // IPv4 protocol is byte 9 of 19 stored, IPv6 next header byte 6 of 39 stored.
    assign sel_type   = {eth_hdr[7:0], in_data};
    assign sel_proto4 = ip4_hdr[79:72];
    assign sel_nh6    = ip6_hdr[263:256];

    hdr_parse_fsm #(.DEPTH_BYTES(DEPTH_BYTES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .beat       (in_valid),
        .sof        (in_sof),
        .eof        (in_eof),
        .eth_type   (sel_type),
        .ip4_proto  (sel_proto4),
        .ip6_nh     (sel_nh6),
        .shift_en   (shift_en),
        .hdr_done   (hdr_done),
        .frame_start(frame_start),
        .publish    (publish),
        .trunc_evt  (trunc_evt),
        .depth_evt  (depth_evt)
    );

    hdr_shift #(.NBYTES(ETH_BYTES)) u_eth (.clk(clk), .en(shift_en[H_ETH]), .din(in_data), .q(eth_hdr));
    hdr_shift #(.NBYTES(IP4_BYTES)) u_ip4 (.clk(clk), .en(shift_en[H_IP4]), .din(in_data), .q(ip4_hdr));
    hdr_shift #(.NBYTES(IP6_BYTES)) u_ip6 (.clk(clk), .en(shift_en[H_IP6]), .din(in_data), .q(ip6_hdr));
    hdr_shift #(.NBYTES(TCP_BYTES)) u_tcp (.clk(clk), .en(shift_en[H_TCP]), .din(in_data), .q(tcp_hdr));
    hdr_shift #(.NBYTES(UDP_BYTES)) u_udp (.clk(clk), .en(shift_en[H_UDP]), .din(in_data), .q(udp_hdr));

    hdr_stream_delay #(.DW(8)) u_pass (
        .clk    (clk),
        .rst    (rst),
        .i_valid(in_valid),
        .i_data (in_data),
        .i_sof  (in_sof),
        .i_eof  (in_eof),
        .o_valid(out_valid),
        .o_data (out_data),
        .o_sof  (out_sof),
        .o_eof  (out_eof)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_trunc <= 1'b0;
            res_depth <= 1'b0;
            hdr_ok    <= '0;
            pt_armed  <= 1'b0;
        end else begin
            pt_armed  <= 1'b1;
            res_valid <= publish;
            if (publish) begin
                res_trunc <= trunc_evt;
                res_depth <= depth_evt;
            end
            hdr_ok <= frame_start ? '0 : (hdr_ok | hdr_done);
        end
    end

    assign eth_ok = hdr_ok[H_ETH];
    assign ip4_ok = hdr_ok[H_IP4];
    assign ip6_ok = hdr_ok[H_IP6];
    assign tcp_ok = hdr_ok[H_TCP];
    assign udp_ok = hdr_ok[H_UDP];

    // Five-tuple assembly
    always_comb begin
        tup_proto = 8'd0;
        tup_src   = '0;
        tup_dst   = '0;
        tup_sport = 16'd0;
        tup_dport = 16'd0;
        if (ip4_ok) begin
            tup_proto = ip4_hdr[87:80];
            tup_src   = {96'd0, ip4_hdr[63:32]};
            tup_dst   = {96'd0, ip4_hdr[31:0]};
        end else if (ip6_ok) begin
            tup_proto = ip6_hdr[271:264];
            tup_src   = ip6_hdr[255:128];
            tup_dst   = ip6_hdr[127:0];
        end
        if (tcp_ok) begin
            tup_sport = tcp_hdr[159:144];
            tup_dport = tcp_hdr[143:128];
        end else if (udp_ok) begin
            tup_sport = udp_hdr[63:48];
            tup_dport = udp_hdr[47:32];
        end
    end

    AST_PASS_TIMING: assert property (@(posedge clk) disable iff (rst)
        pt_armed |-> (out_valid == $past(in_valid)))
        else $error("forwarded valid not one cycle behind"); // R2

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid)
        else $error("result strobe longer than one cycle"); // R9

    AST_RESULT_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        (pt_armed && res_valid) |-> $past(in_valid))
        else $error("result without an accepted byte"); // R9

    AST_ONE_IP: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !(ip4_ok && ip6_ok))
        else $error("both IP layers flagged"); // R4

    AST_IP_NEEDS_ETH: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (ip4_ok || ip6_ok)) |-> eth_ok)
        else $error("IP flag without link layer"); // R4

    AST_L4_NEEDS_IP: assert property (@(posedge clk) disable iff (rst)
        (res_valid && (tcp_ok || udp_ok)) |-> ((ip4_ok || ip6_ok) && !(tcp_ok && udp_ok)))
        else $error("transport flag inconsistent"); // R7

    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !(res_trunc && res_depth))
        else $error("truncation and depth both flagged"); // R11

endmodule

// File: tb/pkt_hdr_parser_tb.sv
`timescale 1ns/1ps
module pkt_hdr_parser_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic         in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]   in_data = 8'd0;
    logic         out_valid, out_sof, out_eof;
    logic [7:0]   out_data;
    logic         res_valid, res_trunc, res_depth;
    logic         eth_ok, ip4_ok, ip6_ok, tcp_ok, udp_ok;
    logic [111:0] eth_hdr;
    logic [159:0] ip4_hdr, tcp_hdr;
    logic [319:0] ip6_hdr;
    logic [63:0]  udp_hdr;
    logic [7:0]   tup_proto;
    logic [127:0] tup_src, tup_dst;
    logic [15:0]  tup_sport, tup_dport;

    // 70-byte depth limit so that IPv6 + TCP reaches it
    pkt_hdr_parser #(.PARSE_DEPTH_BITS(560)) u_dut (.*);

    typedef struct {
        logic [4:0]   ok;
        logic         tr, dp;
        logic [111:0] eth;
        logic [159:0] ip4, tcp;
        logic [319:0] ip6;
        logic [63:0]  udp;
        logic [295:0] tup;
        int           cyc;
        string        tag;
    } exp_t;

    exp_t       sbq[$];
    logic [7:0] fb[$];
    int nchk = 0, nfail = 0, cyc = 0, pt_bad = 0;

    task automatic chk(bit c, string tag, logic [319:0] a, logic [319:0] e);
        nchk++;
        if (!c) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, a, e);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            nchk++; nfail++;
            $display("FAIL R9 watchdog expired act=%0d exp=<20000", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    // Monitor / scoreboard, sampled just after the edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            // R2 forwarded stream equals the input seen at this edge
            if (out_valid !== in_valid ||
                (in_valid && (out_data !== in_data || out_sof !== in_sof || out_eof !== in_eof)))
                pt_bad++;
            if (res_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R9 unexpected result strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(cyc == e.cyc, {e.tag, " R9 strobe cycle"}, cyc, e.cyc);
                    chk({udp_ok, tcp_ok, ip6_ok, ip4_ok, eth_ok} == e.ok,
                        {e.tag, " R4 R7 layer flags"}, {udp_ok, tcp_ok, ip6_ok, ip4_ok, eth_ok}, e.ok);
                    chk({res_trunc, res_depth} == {e.tr, e.dp},
                        {e.tag, " R11 R12 error flags"}, {res_trunc, res_depth}, {e.tr, e.dp});
                    if (e.ok[0]) chk(eth_hdr == e.eth, {e.tag, " R3 link header"}, eth_hdr, e.eth);
                    if (e.ok[1]) chk(ip4_hdr == e.ip4, {e.tag, " R5 ipv4 header"}, ip4_hdr, e.ip4);
                    if (e.ok[2]) chk(ip6_hdr == e.ip6, {e.tag, " R6 ipv6 header"}, ip6_hdr, e.ip6);
                    if (e.ok[3]) chk(tcp_hdr == e.tcp, {e.tag, " R8 tcp header"}, tcp_hdr, e.tcp);
                    if (e.ok[4]) chk(udp_hdr == e.udp, {e.tag, " R8 udp header"}, udp_hdr, e.udp);
                    chk({tup_proto, tup_src, tup_dst, tup_sport, tup_dport} == e.tup,
                        {e.tag, " R10 five-tuple"},
                        {tup_proto, tup_src, tup_dst, tup_sport, tup_dport}, e.tup);
                end
            end
        end
    end

    // Frame builders
    task automatic put(int n, logic [127:0] v);
        for (int i = n - 1; i >= 0; i--) fb.push_back(v[i*8 +: 8]);
    endtask

    task automatic mk_eth(logic [15:0] t);
        fb.delete();
        put(6, 48'h0a1b2c3d4e5f); put(6, 48'h665544332211); put(2, t);
    endtask

    task automatic mk_ip4(logic [3:0] ihl, logic [7:0] pr, logic [31:0] s, logic [31:0] d);
        put(1, {4'h4, ihl}); put(1, 8'h10); put(2, 16'd46); put(2, 16'h1234);
        put(2, 16'h4000); put(1, 8'd64); put(1, pr); put(2, 16'hbeef); put(4, s); put(4, d);
    endtask

    task automatic mk_ip6(logic [7:0] nh, logic [127:0] s, logic [127:0] d);
        put(4, 32'h60012345); put(2, 16'd20); put(1, nh); put(1, 8'd255); put(16, s); put(16, d);
    endtask

    task automatic mk_tcp(logic [15:0] sp, logic [15:0] dp);
        put(2, sp); put(2, dp); put(4, 32'h01020304); put(4, 32'h0a0b0c0d);
        put(1, 8'hf0); put(1, 8'h12); put(2, 16'hffff); put(2, 16'h5a5a); put(2, 16'h0000);
    endtask

    task automatic mk_udp(logic [15:0] sp, logic [15:0] dp);
        put(2, sp); put(2, dp); put(2, 16'd8); put(2, 16'h0000);
    endtask

    task automatic pad(int n);
        for (int i = 0; i < n; i++) fb.push_back(8'(8'h80 + i));
    endtask

    task automatic cut(int n);
        while (fb.size() > n) void'(fb.pop_back());
    endtask

    function automatic logic [319:0] pack(int off, int n);
        logic [319:0] r = '0;
        for (int i = 0; i < n; i++) r = {r[311:0], fb[off + i]};
        return r;
    endfunction

    // Driver: computes the expected item from the built bytes and sends the frame
    task automatic run(string tag, logic [4:0] ok, bit tr, bit dp, int stop_idx,
                       int o_ip, int o_l4, int gap_at);
        exp_t it;
        logic [7:0]   pr;
        logic [127:0] s, d;
        logic [15:0]  sp, dpt;
        it.tag = tag; it.ok = ok; it.tr = tr; it.dp = dp;
        it.eth = pack(0, 14)[111:0];
        it.ip4 = ok[1] ? pack(o_ip, 20)[159:0] : '0;
        it.ip6 = ok[2] ? pack(o_ip, 40) : '0;
        it.tcp = ok[3] ? pack(o_l4, 20)[159:0] : '0;
        it.udp = ok[4] ? pack(o_l4, 8)[63:0] : '0;
        pr = 8'd0; s = '0; d = '0; sp = 16'd0; dpt = 16'd0;
        if (ok[1]) begin pr = it.ip4[87:80]; s = {96'd0, it.ip4[63:32]}; d = {96'd0, it.ip4[31:0]}; end
        else if (ok[2]) begin pr = it.ip6[271:264]; s = it.ip6[255:128]; d = it.ip6[127:0]; end
        if (ok[3]) begin sp = it.tcp[159:144]; dpt = it.tcp[143:128]; end
        else if (ok[4]) begin sp = it.udp[63:48]; dpt = it.udp[47:32]; end
        it.tup = {pr, s, d, sp, dpt};
        pt_bad = 0;
        for (int i = 0; i < fb.size(); i++) begin
            @(negedge clk);
            if (i == gap_at) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = fb[i];
            in_sof   = (i == 0);
            in_eof   = (i == fb.size() - 1);
            if (i == stop_idx) begin
                it.cyc = cyc + 1;
                sbq.push_back(it);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        repeat (4) @(negedge clk);
        chk(pt_bad == 0, {tag, " R2 forwarded stream"}, pt_bad, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk({res_valid, out_valid, res_trunc, res_depth, eth_ok, ip4_ok, ip6_ok, tcp_ok, udp_ok} == 9'd0,
            "R1 reset outputs",
            {res_valid, out_valid, res_trunc, res_depth, eth_ok, ip4_ok, ip6_ok, tcp_ok, udp_ok}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R5 R8 IPv4+TCP, odd IHL and data offset ignored, gap mid-header (R9)
        mk_eth(16'h0800); mk_ip4(4'h7, 8'd6, 32'hc0a80001, 32'h0a000002); mk_tcp(16'd1234, 16'd80); pad(6);
        run("ip4tcp", 5'b01011, 0, 0, 53, 14, 34, 20);
        // IPv4+UDP ending on the last UDP byte
        mk_eth(16'h0800); mk_ip4(4'h5, 8'd17, 32'h01020304, 32'h05060708); mk_udp(16'd53, 16'd5353);
        run("ip4udp", 5'b10011, 0, 0, 41, 14, 34, -1);
        // R6 IPv6+UDP
        mk_eth(16'h86DD); mk_ip6(8'd17, 128'h20010db8000000000000000000000001,
                                 128'h20010db80000000000000000000000ff); mk_udp(16'd4000, 16'd4001); pad(4);
        run("ip6udp", 5'b10101, 0, 0, 61, 14, 54, -1);
        // R12 IPv6+TCP runs into the 70-byte limit inside TCP
        mk_eth(16'h86DD); mk_ip6(8'd6, 128'hfe800000000000000000000000000011,
                                 128'hfe800000000000000000000000000022); mk_tcp(16'd22, 16'd2222); pad(6);
        run("depth", 5'b00101, 0, 1, 69, 14, 54, -1);
        // R4 other type
        mk_eth(16'h0806); pad(46);
        run("arp", 5'b00001, 0, 0, 13, 14, 14, -1);
        // R7 IPv4 with ICMP
        mk_eth(16'h0800); mk_ip4(4'h5, 8'd1, 32'hac100001, 32'hac100002); pad(16);
        run("icmp4", 5'b00011, 0, 0, 33, 14, 34, -1);
        // R7 IPv6 with next header 58
        mk_eth(16'h86DD); mk_ip6(8'd58, 128'h1, 128'h2); pad(16);
        run("icmp6", 5'b00101, 0, 0, 53, 14, 54, -1);
        // R11 truncated inside IPv4
        mk_eth(16'h0800); mk_ip4(4'h5, 8'd6, 32'h1, 32'h2); cut(25);
        run("cut_ip4", 5'b00001, 1, 0, 24, 14, 34, -1);
        // R11 frame ends exactly after type selecting IPv4
        mk_eth(16'h0800);
        run("cut_sel", 5'b00001, 1, 0, 13, 14, 34, -1);
        // R11 truncated inside UDP
        mk_eth(16'h0800); mk_ip4(4'h5, 8'd17, 32'h0a0a0a0a, 32'h0b0b0b0b); mk_udp(16'd7, 16'd9); cut(38);
        run("cut_udp", 5'b00011, 1, 0, 37, 14, 34, -1);
        // R11 truncated inside the link header
        mk_eth(16'h0800); cut(10);
        run("cut_eth", 5'b00000, 1, 0, 9, 14, 34, -1);

        repeat (6) @(negedge clk);
        chk(sbq.size() == 0, "R9 every expected strobe seen", sbq.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule